// File: doc/BRIEF.md
# Paged Address Translator with Write Locks

This block turns a 17-bit virtual word address into an actual word address through a page map of 256 byte-wide entries, each page spanning 512 words. When mapping is on, the upper eight address bits index the map and are replaced by the stored frame byte. The low nine bits pass through untouched. When mapping is off, the address passes through unchanged.

Each page also carries a 2-bit write lock that is compared against a 2-bit key sent with the request. A zero lock leaves the page open to every writer. A zero key opens every page. Any other pairing permits the write only when the key and the lock match. A rejected write raises a fault flag and drops the write strobe in the same output cycle.

Software fills the map through a load port. Each load writes four neighbouring entries, and each entry takes both its frame byte and its lock. Each translation result appears in registered outputs one clock after the request.

Top module: `paged_xlat`

## Requirements
- R1: After reset, rsp_valid_o, rsp_fault_o and rsp_wr_o are 0 and rsp_addr_o is 0. Every map entry i holds frame i (identity) and every lock is 00.
- R2: A request with req_map_en_i=1 yields, one clock later, rsp_valid_o=1 and rsp_addr_o = {frame of page req_vaddr_i[16:9], req_vaddr_i[8:0]}.
- R3: A request with req_map_en_i=0 yields, one clock later, rsp_addr_o equal to req_vaddr_i.
- R4: A write to a page whose lock is 00 is permitted for every key value: rsp_wr_o=1 and rsp_fault_o=0.
- R5: A write with key 00 is permitted on every page whatever its lock: rsp_wr_o=1 and rsp_fault_o=0.
- R6: When both the lock and the key are nonzero, a write is permitted only if key equals lock. Otherwise rsp_fault_o=1 and rsp_wr_o=0 in the same cycle.
- R7: A read (req_write_i=0) never faults and never raises rsp_wr_o, whatever the lock and key.
- R8: A load with group g writes entries 4g+j for j=0..3. Entry 4g+j takes frame ld_map_i[8j+7:8j] and lock ld_lock_i[2j+1:2j]. All other entries keep their contents.
- R9: The lock check uses the lock of page req_vaddr_i[16:9] even when mapping is disabled.
- R10: A request in the same clock as a load that rewrites its page sees the contents held before that load. The next request sees the new contents.
- R11: One clock after a cycle with req_valid_i=0, rsp_valid_o, rsp_fault_o and rsp_wr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load four map entries this cycle |
| ld_group_i | input | 6 | Group index; entries 4g..4g+3 |
| ld_map_i | input | 32 | Four frame bytes, entry 4g+j in byte j |
| ld_lock_i | input | 8 | Four locks, entry 4g+j in bits 2j+1:2j |
| req_valid_i | input | 1 | Translation request present |
| req_vaddr_i | input | 17 | Virtual word address |
| req_write_i | input | 1 | Request is a write |
| req_map_en_i | input | 1 | Apply the page map |
| req_key_i | input | 2 | Program write key |
| rsp_valid_o | output | 1 | Registered result valid |
| rsp_addr_o | output | 17 | Actual word address; held while no request |
| rsp_fault_o | output | 1 | Write rejected by lock check |
| rsp_wr_o | output | 1 | Write strobe for a permitted write |

## Verification
The checker assumes that request inputs are stable around the clock edge and are zero throughout reset, so that the one-cycle look-back after reset sees a quiet port. It also treats rsp_addr_o as meaningful only in cycles where rsp_valid_o is high. The bench drives every input at the falling edge, holds all of them low during reset, and compares rsp_addr_o against its own model only when a result is valid. The flags are compared in every cycle.

// File: rtl/paged_xlat_pkg.sv
package paged_xlat_pkg;
  localparam int LOCK_W = 2;
  typedef logic [LOCK_W-1:0] lock_t;

  // zero on either side is a free pass; else exact match
  function automatic logic lock_permits(lock_t lock, lock_t key);
    return (lock == '0) || (key == '0) || (lock == key);
  endfunction
endpackage

// File: rtl/paged_xlat_store.sv
module paged_xlat_store
  import paged_xlat_pkg::*;
#(
  parameter int PAGE_BITS = 8,
  parameter int GROUP     = 4,
  localparam int ENTRIES  = 1 << PAGE_BITS,
  localparam int NGRP     = ENTRIES / GROUP,
  localparam int GRP_W    = $clog2(NGRP)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ld_valid_i,
  input  logic [GRP_W-1:0]           ld_group_i,
  input  logic [GROUP*PAGE_BITS-1:0] ld_map_i,
  input  logic [GROUP*LOCK_W-1:0]    ld_lock_i,
  input  logic [PAGE_BITS-1:0]       rd_page_i,
  output logic [PAGE_BITS-1:0]       rd_frame_o,
  output lock_t                      rd_lock_o
);
  logic [PAGE_BITS-1:0] map_q  [ENTRIES];
  lock_t                lock_q [ENTRIES];
  logic [NGRP-1:0]      grp_we;

  for (genvar g = 0; g < NGRP; g++) begin : g_we
    assign grp_we[g] = ld_valid_i && (ld_group_i == GRP_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) begin
        map_q[e]  <= e[PAGE_BITS-1:0];
        lock_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (grp_we[e/GROUP]) begin
          map_q[e]  <= ld_map_i[(e%GROUP)*PAGE_BITS +: PAGE_BITS];
          lock_q[e] <= ld_lock_i[(e%GROUP)*LOCK_W +: LOCK_W];
        end
      end
    end
  end

  assign rd_frame_o = map_q[rd_page_i];
  assign rd_lock_o  = lock_q[rd_page_i];
endmodule

// File: rtl/paged_xlat_guard.sv
module paged_xlat_guard
  import paged_xlat_pkg::*;
(
  input  lock_t lock_i,
  input  lock_t key_i,
  input  logic  valid_i,
  input  logic  write_i,
  output logic  fault_o,
  output logic  strobe_o
);
  logic permit;
  assign permit   = lock_permits(lock_i, key_i);
  assign fault_o  = valid_i && write_i && !permit;
  assign strobe_o = valid_i && write_i && permit;
endmodule

// File: rtl/paged_xlat.sv
module paged_xlat
  import paged_xlat_pkg::*;
#(
  parameter int VA_W      = 17,
  parameter int PAGE_BITS = 8,
  parameter int GROUP     = 4,
  localparam int OFF_W    = VA_W - PAGE_BITS,
  localparam int GRP_W    = $clog2((1 << PAGE_BITS) / GROUP)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ld_valid_i,
  input  logic [GRP_W-1:0]           ld_group_i,
  input  logic [GROUP*PAGE_BITS-1:0] ld_map_i,
  input  logic [GROUP*LOCK_W-1:0]    ld_lock_i,
  input  logic                       req_valid_i,
  input  logic [VA_W-1:0]            req_vaddr_i,
  input  logic                       req_write_i,
  input  logic                       req_map_en_i,
  input  logic [LOCK_W-1:0]          req_key_i,
  output logic                       rsp_valid_o,
  output logic [VA_W-1:0]            rsp_addr_o,
  output logic                       rsp_fault_o,
  output logic                       rsp_wr_o
);
  logic [PAGE_BITS-1:0] frame;
  lock_t                lock;
  logic                 fault_d, strobe_d;
  logic [VA_W-1:0]      addr_d;

  paged_xlat_store #(.PAGE_BITS(PAGE_BITS), .GROUP(GROUP)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_valid_i (ld_valid_i),
    .ld_group_i (ld_group_i),
    .ld_map_i   (ld_map_i),
    .ld_lock_i  (ld_lock_i),
    .rd_page_i  (req_vaddr_i[VA_W-1 -: PAGE_BITS]),
    .rd_frame_o (frame),
    .rd_lock_o  (lock)
  );

  paged_xlat_guard u_guard (
    .lock_i   (lock),
    .key_i    (req_key_i),
    .valid_i  (req_valid_i),
    .write_i  (req_write_i),
    .fault_o  (fault_d),
    .strobe_o (strobe_d)
  );

  assign addr_d = req_map_en_i ? {frame, req_vaddr_i[OFF_W-1:0]} : req_vaddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_fault_o <= 1'b0;
      rsp_wr_o    <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= fault_d;
      rsp_wr_o    <= strobe_d;
      if (req_valid_i) rsp_addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/paged_xlat_chk.sv
module paged_xlat_chk #(
  parameter int VA_W  = 17,
  parameter int OFF_W = 9
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_write_i,
  input logic            req_map_en_i,
  input logic [1:0]      req_key_i,
  input logic [VA_W-1:0] req_vaddr_i,
  input logic            rsp_valid_o,
  input logic [VA_W-1:0] rsp_addr_o,
  input logic            rsp_fault_o,
  input logic            rsp_wr_o
);
  a_r6_fault_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> !rsp_wr_o);

  a_r6_flag_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fault_o || rsp_wr_o) |-> rsp_valid_o);

  a_r7_read_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> (!rsp_fault_o && !rsp_wr_o));

  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_fault_o && !rsp_wr_o));

  a_r3_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_map_en_i) |=> (rsp_addr_o == $past(req_vaddr_i)));

  a_r2_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_addr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0])));

  a_r5_key_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_key_i == 2'b00) |=> rsp_wr_o);
endmodule

bind paged_xlat paged_xlat_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .req_map_en_i (req_map_en_i),
  .req_key_i    (req_key_i),
  .req_vaddr_i  (req_vaddr_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_addr_o   (rsp_addr_o),
  .rsp_fault_o  (rsp_fault_o),
  .rsp_wr_o     (rsp_wr_o)
);

// File: tb/paged_xlat_test.sv
`timescale 1ns/1ps
module paged_xlat_test;
  localparam int VA_W = 17, PB = 8, OFF = VA_W - PB, GROUP = 4;
  localparam int ENT = 1 << PB, GW = $clog2(ENT / GROUP);

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic ld_valid = 0; logic [GW-1:0] ld_group = '0;
  logic [31:0] ld_map = '0; logic [7:0] ld_lock = '0;
  logic req_valid = 0, req_write = 0, req_map_en = 0;
  logic [VA_W-1:0] req_vaddr = '0; logic [1:0] req_key = '0;
  logic rsp_valid, rsp_fault, rsp_wr; logic [VA_W-1:0] rsp_addr;

  paged_xlat uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ld_valid_i(ld_valid), .ld_group_i(ld_group), .ld_map_i(ld_map), .ld_lock_i(ld_lock),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .req_map_en_i(req_map_en), .req_key_i(req_key),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_fault_o(rsp_fault), .rsp_wr_o(rsp_wr)
  );

  int map_m[ENT];
  int lock_m[ENT];
  int total = 0, bad = 0;
  bit done = 0;
  logic e_valid = 0, e_fault = 0, e_wr = 0;
  logic [VA_W-1:0] e_addr = '0;

  task automatic check(string tag);
    total++;
    if (rsp_valid !== e_valid || rsp_fault !== e_fault || rsp_wr !== e_wr ||
        (e_valid && rsp_addr !== e_addr)) begin
      bad++;
      $display("FAIL %s: actual v=%b a=%h f=%b w=%b expected v=%b a=%h f=%b w=%b",
               tag, rsp_valid, rsp_addr, rsp_fault, rsp_wr, e_valid, e_addr, e_fault, e_wr);
    end
  endtask

  task automatic cyc(string tag, bit v, bit w, bit me, int key, int va,
                     bit lv, int lg, logic [31:0] lm, logic [7:0] ll);
    int page, lk;
    bit ok;
    req_valid = v; req_write = w; req_map_en = me; req_key = key[1:0];
    req_vaddr = va[VA_W-1:0];
    ld_valid = lv; ld_group = lg[GW-1:0]; ld_map = lm; ld_lock = ll;
    page = (va >> OFF) & (ENT - 1);
    lk = lock_m[page];
    ok = (lk == 0) || (key == 0) || (lk == key);
    e_valid = v;
    e_fault = v && w && !ok;
    e_wr = v && w && ok;
    if (v) e_addr = me ? VA_W'((map_m[page] << OFF) | (va & ((1 << OFF) - 1))) : va[VA_W-1:0];
    if (lv) for (int j = 0; j < GROUP; j++) begin
      map_m[lg*GROUP + j]  = int'(lm[8*j +: 8]);
      lock_m[lg*GROUP + j] = int'(ll[2*j +: 2]);
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic req(string tag, bit w, bit me, int key, int va);
    cyc(tag, 1, w, me, key, va, 0, 0, 32'h0, 8'h0);
  endtask

  task automatic load(int g, logic [31:0] lm, logic [7:0] ll);
    cyc("R11", 0, 0, 0, 0, 0, 1, g, lm, ll);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string t;
    for (int i = 0; i < ENT; i++) begin map_m[i] = i; lock_m[i] = 0; end
    #2;
    check("R1");
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    // identity after reset; writes open with any key
    req("R1", 1, 1, 3, (7 << OFF) | 5);
    req("R1", 1, 1, 2, (200 << OFF) | 300);
    req("R1", 0, 1, 1, (255 << OFF) | 511);
    // idle
    cyc("R11", 0, 1, 1, 3, 12345, 0, 0, 0, 0);
    // group 10: pages 40..43 frames, locks 0,1,2,3
    load(10, 32'h9C_B1_07_E5, 8'hE4);
    for (int p = 36; p < 48; p++) req("R8", 0, 1, 1, (p << OFF) | p);
    req("R2", 0, 1, 0, (41 << OFF) | 9'h1AB);
    req("R3", 0, 0, 0, (41 << OFF) | 9'h1AB);
    for (int p = 40; p < 44; p++)
      for (int k = 0; k < 4; k++) begin
        t = (p == 40) ? "R4" : (k == 0) ? "R5" : "R6";
        req(t, 1, 1, k, (p << OFF) | (k * 17));
        req("R9", 1, 0, k, (p << OFF) | (k * 33));
        req("R7", 0, 1, k, (p << OFF) | k);
      end
    // same-cycle load and request to page 50
    cyc("R10", 1, 1, 1, 1, (50 << OFF) | 3, 1, 12, 32'h11_22_33_44, 8'h55);
    req("R10", 1, 1, 1, (50 << OFF) | 3);
    req("R10", 1, 1, 3, (50 << OFF) | 3);
    // load with request off: no effect at outputs
    cyc("R11", 0, 1, 0, 2, 99, 1, 63, 32'hA5_5A_C3_3C, 8'h1B);
    req("R2", 1, 1, 2, (253 << OFF) | 1);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int va, g;
      bit v, w, me, lv;
      va = int'($urandom_range(0, (1 << VA_W) - 1));
      g  = int'($urandom_range(0, ENT / GROUP - 1));
      v = ($urandom_range(0, 3) != 0); w = $urandom_range(0, 1) != 0;
      me = $urandom_range(0, 1) != 0; lv = ($urandom_range(0, 4) == 0);
      t = !v ? "R11" : !w ? "R7" : me ? "R2" : "R3";
      cyc(t, v, w, me, int'($urandom_range(0, 3)), va, lv, g, $urandom, 8'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule